// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides, for each received frame, whether the frame is kept, using only its 48-bit destination address. The lookup runs three checks in a fixed order. First, a per-class promiscuous test accepts broadcast, group or individual addresses outright when the matching enable is set. Second, the address is compared at once against a table of exact entries, each gated by its own valid flag. Third, a 12-bit hash taken from the two last address bytes picks one bit of a 4096-bit table.

A clear class enable does not reject a frame. It only passes the frame on to the exact table and then to the hash table. The frame is rejected only when all three checks fail. The receive path presents an address with a one-cycle strobe. One cycle later the block returns the accept flag, and also whether an exact entry matched and which one.

Host logic loads both tables through two simple write ports.

Top module: `dafilt_top`

## Requirements
- R1: Address byte k sits on `dst_addr[8k+7:8k]`, and the group bit is `dst_addr[0]`. An all-ones address is broadcast. It is accepted when `bcast_acc` is 1, whatever the tables hold.
- R2: An address with bit 0 set that is not all-ones is accepted when `mcast_prom` is 1. `mcast_prom` does not accept a broadcast address.
- R3: An address with bit 0 clear is accepted when `ucast_prom` is 1. `ucast_prom` does not accept group addresses.
- R4: When an address's class enable is clear, the frame is not rejected at that stage. The exact and hash checks still decide, for broadcast as well.
- R5: The exact entry `ex_wr_idx` is written as follows. Bytes 0–3 come from `ex_wr_lo` (little-endian). Bytes 4–5 come from `ex_wr_hi[15:0]`. The valid flag comes from `ex_wr_hi[31]`. A valid entry equal to the address accepts the frame and raises `dec_hit`.
- R6: An exact entry whose valid flag is 0 never matches.
- R7: When several valid entries match, `dec_idx` gives the lowest-numbered one. `dec_hit` and `dec_idx` report the exact-table result even when a promiscuous enable has already accepted the frame.
- R8: The hash index is formed as follows. Take the 16-bit value `{byte5, byte4}`. Shift it right by 4, 3, 2 or 0 for `hash_ofs` codes 0, 1, 2 and 3. Keep the low 12 bits.
- R9: Hash index bits [11:5] select the table word written through `hash_wr_idx`/`hash_wr_data`, and bits [4:0] select a bit in that word. A set bit accepts the frame. If the bit is clear and the earlier checks did not accept, the frame is rejected.
- R10: `dec_vld` is high for exactly the one cycle after each cycle in which `addr_vld` is high. `dec_accept`, `dec_hit` and `dec_idx` change only at that point and hold otherwise.
- R11: After reset, `dec_vld`, `dec_accept` and `dec_hit` are 0, every exact entry is invalid and every hash bit is 0.
- R12: A table write in the same cycle as a lookup takes effect only for later lookups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_vld | input | 1 | Lookup strobe |
| dst_addr | input | 48 | Destination address, byte 0 in bits 7:0 |
| bcast_acc | input | 1 | Accept broadcast |
| mcast_prom | input | 1 | Accept all non-broadcast group addresses |
| ucast_prom | input | 1 | Accept all individual addresses |
| hash_ofs | input | 2 | Hash window select |
| ex_wr_en | input | 1 | Exact entry write enable |
| ex_wr_idx | input | 4 | Exact entry number |
| ex_wr_lo | input | 32 | Address bytes 0–3 |
| ex_wr_hi | input | 32 | Bytes 4–5 in [15:0], valid in [31] |
| hash_wr_en | input | 1 | Hash word write enable |
| hash_wr_idx | input | 7 | Hash word number |
| hash_wr_data | input | 32 | Hash word contents |
| dec_vld | output | 1 | Decision valid |
| dec_accept | output | 1 | Frame accepted |
| dec_hit | output | 1 | A valid exact entry matched |
| dec_idx | output | 4 | Lowest matching exact entry |

## Verification
The bench targets class boundaries first. A broadcast address offered with only `mcast_prom` set must be rejected; a design that treats broadcast as ordinary multicast would accept it. A broadcast address with `bcast_acc` clear must still be accepted through a table entry; a design that rejects on a clear class bit would drop it.

On the exact table, the bench writes duplicate entries, some invalid. A design that ignores the valid flag, or picks the highest-numbered match, reports the wrong index. For the hash, each offset code is paired with a lookup under a different code and with a neighbouring bit set. A wrong shift or a swapped word/bit split shows up as a false accept or a false reject.

A lookup issued in the same cycle as a table write checks that the new entry does not take effect early.

// File: rtl/dafilt_pkg.sv
package dafilt_pkg;

  typedef enum logic [1:0] {
    CLS_UCAST = 2'd0,
    CLS_MCAST = 2'd1,
    CLS_BCAST = 2'd2
  } dest_cls_e;

  // right shift applied to {byte5,byte4} for each window code
  function automatic int unsigned hash_shift(input logic [1:0] code);
    case (code)
      2'd0:    hash_shift = 4;
      2'd1:    hash_shift = 3;
      2'd2:    hash_shift = 2;
      default: hash_shift = 0;
    endcase
  endfunction

endpackage

// File: rtl/dafilt_class.sv
module dafilt_class
  import dafilt_pkg::*;
#(
  parameter int ADDR_W = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] dst_addr,
  input  logic              bcast_acc,
  input  logic              mcast_prom,
  input  logic              ucast_prom,
  output dest_cls_e         cls,
  output logic              prom_hit
);

  always_comb begin
    if (&dst_addr)        cls = CLS_BCAST;
    else if (dst_addr[0]) cls = CLS_MCAST;
    else                  cls = CLS_UCAST;
  end

  always_comb begin
    case (cls)
      CLS_BCAST: prom_hit = bcast_acc;
      CLS_MCAST: prom_hit = mcast_prom;
      default:   prom_hit = ucast_prom;
    endcase
  end

  // R1 R2 R3
  prom_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prom_hit |-> (bcast_acc || mcast_prom || ucast_prom));

endmodule

// File: rtl/dafilt_exact_tbl.sv
module dafilt_exact_tbl #(
  parameter int ADDR_W    = 48,
  parameter int N_EXACT   = 16,
  parameter int REG_W     = 32,
  parameter int VALID_BIT = 31,
  localparam int IDX_W    = $clog2(N_EXACT),
  localparam int HI_W     = ADDR_W - REG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [REG_W-1:0]  wr_lo,
  input  logic [REG_W-1:0]  wr_hi,
  input  logic [ADDR_W-1:0] dst_addr,
  output logic              match_hit,
  output logic [IDX_W-1:0]  match_idx
);

  localparam logic [N_EXACT-1:0] ONE_VEC = {{(N_EXACT-1){1'b0}}, 1'b1};

  logic [ADDR_W-1:0]  ent_addr_q [N_EXACT];
  logic [N_EXACT-1:0] ent_vld_q;
  logic [N_EXACT-1:0] cmp_vec;
  logic [ADDR_W-1:0]  wr_addr;
  logic               wr_vld;
  logic               unused_hi_bits;

  assign wr_addr        = {wr_hi[HI_W-1:0], wr_lo};
  assign wr_vld         = wr_hi[VALID_BIT];
  assign unused_hi_bits = ^wr_hi;

  for (genvar g = 0; g < N_EXACT; g++) begin : g_ent
    logic              sel;
    logic [ADDR_W-1:0] addr_d;
    logic              vld_d;

    assign sel = wr_en && (wr_idx == IDX_W'(g));

    always_comb begin
      addr_d = ent_addr_q[g];
      vld_d  = ent_vld_q[g];
      if (sel) begin
        addr_d = wr_addr;
        vld_d  = wr_vld;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_addr_q[g] <= '0;
        ent_vld_q[g]  <= 1'b0;
      end else if (sel) begin
        ent_addr_q[g] <= addr_d;
        ent_vld_q[g]  <= vld_d;
      end
    end

    assign cmp_vec[g] = ent_vld_q[g] && (ent_addr_q[g] == dst_addr);
  end

  assign match_hit = |cmp_vec;

  always_comb begin
    match_idx = '0;
    for (int i = N_EXACT - 1; i >= 0; i--) begin
      if (cmp_vec[i]) match_idx = IDX_W'(i);
    end
  end

  // R6
  hit_entry_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_hit |-> ent_vld_q[match_idx]);

  // R7
  hit_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_hit |-> ((cmp_vec & ((ONE_VEC << match_idx) - ONE_VEC)) == '0));

  // R5
  entry_written_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ent_vld_q[$past(wr_idx)] == $past(wr_hi[VALID_BIT])));

endmodule

// File: rtl/dafilt_hash_tbl.sv
module dafilt_hash_tbl
  import dafilt_pkg::*;
#(
  parameter int ADDR_W    = 48,
  parameter int HASH_BITS = 4096,
  parameter int WORD_W    = 32,
  localparam int N_WORDS  = HASH_BITS / WORD_W,
  localparam int WSEL_W   = $clog2(N_WORDS),
  localparam int BSEL_W   = $clog2(WORD_W),
  localparam int HIDX_W   = WSEL_W + BSEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WSEL_W-1:0] wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] dst_addr,
  input  logic [1:0]        ofs,
  output logic              hash_hit
);

  logic [WORD_W-1:0] word_q [N_WORDS];
  logic [15:0]       key;
  logic [HIDX_W-1:0] hidx;
  logic [WORD_W-1:0] rd_word;

  for (genvar g = 0; g < N_WORDS; g++) begin : g_word
    logic              sel;
    logic [WORD_W-1:0] word_d;

    assign sel = wr_en && (wr_idx == WSEL_W'(g));

    always_comb begin
      word_d = word_q[g];
      if (sel) word_d = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   word_q[g] <= '0;
      else if (sel) word_q[g] <= word_d;
    end
  end

  assign key      = dst_addr[47:32];
  assign hidx     = HIDX_W'(key >> hash_shift(ofs));
  assign rd_word  = word_q[hidx[HIDX_W-1:BSEL_W]];
  assign hash_hit = rd_word[hidx[BSEL_W-1:0]];

  // R9
  word_written_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (word_q[$past(wr_idx)] == $past(wr_data)));

endmodule

// File: rtl/dafilt_top.sv
module dafilt_top
  import dafilt_pkg::*;
#(
  parameter int ADDR_W    = 48,
  parameter int N_EXACT   = 16,
  parameter int HASH_BITS = 4096,
  parameter int WORD_W    = 32,
  localparam int IDX_W    = $clog2(N_EXACT),
  localparam int WSEL_W   = $clog2(HASH_BITS / WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_vld,
  input  logic [ADDR_W-1:0] dst_addr,
  input  logic              bcast_acc,
  input  logic              mcast_prom,
  input  logic              ucast_prom,
  input  logic [1:0]        hash_ofs,
  input  logic              ex_wr_en,
  input  logic [IDX_W-1:0]  ex_wr_idx,
  input  logic [WORD_W-1:0] ex_wr_lo,
  input  logic [WORD_W-1:0] ex_wr_hi,
  input  logic              hash_wr_en,
  input  logic [WSEL_W-1:0] hash_wr_idx,
  input  logic [WORD_W-1:0] hash_wr_data,
  output logic              dec_vld,
  output logic              dec_accept,
  output logic              dec_hit,
  output logic [IDX_W-1:0]  dec_idx
);

  dest_cls_e        cls;
  logic             prom_hit;
  logic             ex_hit;
  logic [IDX_W-1:0] ex_idx;
  logic             hash_hit;
  logic             unused_cls;

  logic             vld_d, acc_d, hit_d;
  logic [IDX_W-1:0] idx_d;
  logic             vld_q, acc_q, hit_q;
  logic [IDX_W-1:0] idx_q;

  assign unused_cls = ^cls;

  dafilt_class #(.ADDR_W(ADDR_W)) u_class (
    .clk        (clk),
    .rst_n      (rst_n),
    .dst_addr   (dst_addr),
    .bcast_acc  (bcast_acc),
    .mcast_prom (mcast_prom),
    .ucast_prom (ucast_prom),
    .cls        (cls),
    .prom_hit   (prom_hit)
  );

  dafilt_exact_tbl #(
    .ADDR_W  (ADDR_W),
    .N_EXACT (N_EXACT),
    .REG_W   (WORD_W)
  ) u_exact (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (ex_wr_en),
    .wr_idx    (ex_wr_idx),
    .wr_lo     (ex_wr_lo),
    .wr_hi     (ex_wr_hi),
    .dst_addr  (dst_addr),
    .match_hit (ex_hit),
    .match_idx (ex_idx)
  );

  dafilt_hash_tbl #(
    .ADDR_W    (ADDR_W),
    .HASH_BITS (HASH_BITS),
    .WORD_W    (WORD_W)
  ) u_hash (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (hash_wr_en),
    .wr_idx   (hash_wr_idx),
    .wr_data  (hash_wr_data),
    .dst_addr (dst_addr),
    .ofs      (hash_ofs),
    .hash_hit (hash_hit)
  );

  // next state: decision fields load only on a lookup strobe
  always_comb begin
    vld_d = addr_vld;
    acc_d = acc_q;
    hit_d = hit_q;
    idx_d = idx_q;
    if (addr_vld) begin
      acc_d = prom_hit || ex_hit || hash_hit;
      hit_d = ex_hit;
      idx_d = ex_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= 1'b0;
      hit_q <= 1'b0;
      idx_q <= '0;
    end else if (addr_vld) begin
      acc_q <= acc_d;
      hit_q <= hit_d;
      idx_q <= idx_d;
    end
  end

  assign dec_vld    = vld_q;
  assign dec_accept = acc_q;
  assign dec_hit    = hit_q;
  assign dec_idx    = idx_q;

  // R10
  dec_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_vld |=> dec_vld);

  // R10
  dec_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_vld |=> !dec_vld);

  // R10
  dec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_vld |=> ($stable(dec_accept) && $stable(dec_hit) && $stable(dec_idx)));

  // R5
  hit_implies_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_hit |-> dec_accept);

endmodule

// File: tb/dafilt_top_tb_top.sv
module dafilt_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        addr_vld = 1'b0;
  logic [47:0] dst_addr = '0;
  logic        bcast_acc = 1'b0, mcast_prom = 1'b0, ucast_prom = 1'b0;
  logic [1:0]  hash_ofs = '0;
  logic        ex_wr_en = 1'b0;
  logic [3:0]  ex_wr_idx = '0;
  logic [31:0] ex_wr_lo = '0, ex_wr_hi = '0;
  logic        hash_wr_en = 1'b0;
  logic [6:0]  hash_wr_idx = '0;
  logic [31:0] hash_wr_data = '0;
  logic        dec_vld, dec_accept, dec_hit;
  logic [3:0]  dec_idx;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  localparam logic [47:0] BC = 48'hFFFF_FFFF_FFFF;
  localparam logic [47:0] MC = 48'hAB12_005E_0001;
  localparam logic [47:0] UA = 48'h5544_3322_1102;
  localparam logic [47:0] UB = 48'h5644_3322_1102;
  localparam logic [47:0] UC = 48'h0C0B_0A09_0802;

  always #5 clk = ~clk;

  dafilt_top dut_i (
    .clk(clk), .rst_n(rst_n), .addr_vld(addr_vld), .dst_addr(dst_addr),
    .bcast_acc(bcast_acc), .mcast_prom(mcast_prom), .ucast_prom(ucast_prom),
    .hash_ofs(hash_ofs), .ex_wr_en(ex_wr_en), .ex_wr_idx(ex_wr_idx),
    .ex_wr_lo(ex_wr_lo), .ex_wr_hi(ex_wr_hi), .hash_wr_en(hash_wr_en),
    .hash_wr_idx(hash_wr_idx), .hash_wr_data(hash_wr_data),
    .dec_vld(dec_vld), .dec_accept(dec_accept), .dec_hit(dec_hit),
    .dec_idx(dec_idx)
  );

  function automatic logic [11:0] hidx(input logic [47:0] a, input logic [1:0] code);
    logic [15:0] key;
    key = {a[47:40], a[39:32]};
    case (code)
      2'd0: return 12'(key >> 4);
      2'd1: return 12'(key >> 3);
      2'd2: return 12'(key >> 2);
      default: return key[11:0];
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr_exact(input logic [3:0] idx, input logic [47:0] a, input logic v);
    @(negedge clk);
    ex_wr_en = 1'b1; ex_wr_idx = idx;
    ex_wr_lo = a[31:0]; ex_wr_hi = {v, 15'h7ABC, a[47:32]};
    @(negedge clk);
    ex_wr_en = 1'b0;
  endtask

  task automatic wr_hash(input logic [6:0] idx, input logic [31:0] data);
    @(negedge clk);
    hash_wr_en = 1'b1; hash_wr_idx = idx; hash_wr_data = data;
    @(negedge clk);
    hash_wr_en = 1'b0;
  endtask

  task automatic lookup(input logic [47:0] a, input logic [1:0] code,
                        input logic b, input logic m, input logic u,
                        input logic e_acc, input logic e_hit,
                        input logic [3:0] e_idx, input string req);
    @(negedge clk);
    dst_addr = a; hash_ofs = code;
    bcast_acc = b; mcast_prom = m; ucast_prom = u;
    addr_vld = 1'b1;
    @(negedge clk);
    addr_vld = 1'b0;
    check(req, "dec_vld", 32'(dec_vld), 32'd1);
    check(req, "dec_accept", 32'(dec_accept), 32'(e_acc));
    check(req, "dec_hit", 32'(dec_hit), 32'(e_hit));
    if (e_hit) check(req, "dec_idx", 32'(dec_idx), 32'(e_idx));
  endtask

  // R11: reset state and empty tables
  task automatic t_reset;
    check("R11", "dec_vld", 32'(dec_vld), 32'd0);
    check("R11", "dec_accept", 32'(dec_accept), 32'd0);
    check("R11", "dec_hit", 32'(dec_hit), 32'd0);
    lookup(UA, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, "R11");
    lookup(MC, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, "R11");
  endtask

  // R1 R2 R3: class promiscuous enables, each only for its class
  task automatic t_prom;
    lookup(BC, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0, "R1");
    lookup(BC, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'd0, "R2");
    lookup(MC, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd0, "R2");
    lookup(MC, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0, "R3");
    lookup(UA, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'd0, "R3");
    lookup(UA, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0, "R3");
  endtask

  // R5 R6 R7 R4: exact table
  task automatic t_exact;
    wr_exact(4'd5, UA, 1'b1);
    lookup(UA, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd5, "R5");
    lookup(UB, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, "R5");
    wr_exact(4'd2, UA, 1'b0);
    lookup(UA, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd5, "R6");
    wr_exact(4'd9, UA, 1'b1);
    lookup(UA, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd5, "R7");
    wr_exact(4'd2, UA, 1'b1);
    lookup(UA, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd2, "R7");
    lookup(UA, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 4'd2, "R7");
    wr_exact(4'd5, UA, 1'b0);
    wr_exact(4'd2, UA, 1'b0);
    lookup(UA, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd9, "R6");
    wr_exact(4'd11, BC, 1'b1);
    lookup(BC, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd11, "R4");
  endtask

  // R8 R9 R4: hash table window per offset code
  task automatic t_hash;
    for (int c = 0; c < 4; c++) begin
      logic [11:0] hi;
      logic [1:0]  alt;
      hi  = hidx(MC, 2'(c));
      alt = 2'(c + 1);
      wr_hash(hi[11:5], 32'd1 << hi[4:0]);
      lookup(MC, 2'(c), 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0, "R8");
      if (hidx(MC, alt) != hi)
        lookup(MC, alt, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, "R8");
      wr_hash(hi[11:5], 32'd1 << (hi[4:0] ^ 5'd1));
      lookup(MC, 2'(c), 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, "R9");
      wr_hash(hi[11:5], 32'd0);
    end
  endtask

  // R12 R10: write during lookup, then hold behaviour
  task automatic t_same_cycle;
    @(negedge clk);
    dst_addr = UC; hash_ofs = 2'd0;
    bcast_acc = 1'b0; mcast_prom = 1'b0; ucast_prom = 1'b0;
    addr_vld = 1'b1;
    ex_wr_en = 1'b1; ex_wr_idx = 4'd7;
    ex_wr_lo = UC[31:0]; ex_wr_hi = {1'b1, 15'd0, UC[47:32]};
    @(negedge clk);
    addr_vld = 1'b0; ex_wr_en = 1'b0;
    check("R12", "dec_accept", 32'(dec_accept), 32'd0);
    lookup(UC, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd7, "R12");
    dst_addr = UB;
    @(negedge clk);
    check("R10", "dec_vld", 32'(dec_vld), 32'd0);
    check("R10", "dec_accept", 32'(dec_accept), 32'd1);
    check("R10", "dec_idx", 32'(dec_idx), 32'd7);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_prom();
    t_exact();
    t_hash();
    t_same_cycle();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

endmodule